// File: doc/BRIEF.md
# Programmable-Cycle Parallel NVM Access Controller

This block drives an asynchronous, SRAM-style parallel non-volatile memory whose accesses have a fixed latency. The device gives no ready handshake. Every access lasts a whole number of system clocks, and that length comes from one of two run-time configuration inputs. One input sets the length of read cycles and the other sets the length of write cycles. An internal command port issues one read or one write at a time. The controller then drives the active-low chip select, output enable and write enable strobes, the address, and the data bus with its drive enable.

At the end of an access the controller reports completion with a single-clock pulse. With that pulse it gives the number of system clocks the access actually took, and for a read it also gives the captured data word. At a 500 MHz system clock one clock is 2 ns, so a cycle of 40 ns to 100 ns is a setting of 20 to 50 clocks. Any setting below two clocks is raised to two. Between accesses the device is deselected and the data bus is released.

Top module: `nvm_cycle_ctrl`

## Requirements
- R1: While in reset, and whenever no access is in progress, chip select, output enable and write enable are all high, the data drive enable is low, and `req_ready` is high.
- R2: A read accepted on a clock edge (`req_valid` high with `req_ready` high) holds chip select and output enable low for exactly L clocks. Those clocks start with the clock that follows acceptance, and write enable stays high throughout. L is the read length.
- R3: A write holds chip select low and the data drive enable high for exactly L clocks, and the data it drives equals the accepted write word on every one of those clocks. Write enable is low for the first L-1 of those clocks and high on the last clock, so the data remains valid after write enable rises.
- R4: A read samples the data bus on its last clock, and the sampled word appears on `done_rdata` during the done pulse.
- R5: Each access ends with `done` high for exactly one clock, on the clock that follows the access's last clock. During that pulse `done_cycles` equals the number of clocks the access held chip select low, and `done_write` is 1 for a write and 0 for a read.
- R6: Read accesses take their length from `rd_cycles` and write accesses take theirs from `wr_cycles`. Neither setting affects the other kind of access.
- R7: A configured length below 2 (the values 0 and 1) gives an access of 2 clocks.
- R8: The length is captured when the request is accepted. A change to `rd_cycles` or `wr_cycles` during an access does not change that access.
- R9: Output enable and write enable are never low on the same clock. The data drive enable is high only during a write, with chip select low and output enable high.
- R10: A request presented while `req_ready` is low is ignored. It starts no access and does not change the address being driven.
- R11: The address captured at acceptance stays on `mem_addr` unchanged for every clock of the access, even if `req_addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (18) | Access address |
| req_wdata | input | DW (16) | Write data |
| rd_cycles | input | CW (8) | Read cycle length in clocks |
| wr_cycles | input | CW (8) | Write cycle length in clocks |
| req_ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-clock completion pulse |
| done_write | output | 1 | Kind of access completed (1 = write) |
| done_cycles | output | CW (8) | Measured length of the completed access |
| done_rdata | output | DW (16) | Data captured by the completed read |
| mem_ce_n | output | 1 | Device chip select, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_addr | output | AW (18) | Device address |
| mem_dq_out | output | DW (16) | Data driven toward the device |
| mem_dq_oe | output | 1 | Data bus drive enable (low = bus released) |
| mem_dq_in | input | DW (16) | Data returned by the device |

## Verification
The assertions check the following on every clock:
- the strobes stay idle whenever the controller is ready;
- output enable and write enable are never low together;
- the bus is driven only during a write;
- the address holds while chip select is low;
- each done pulse lasts one clock;
- write enable is already high, with data still driven, on the last clock of a write;
- every reported length is at least the minimum.

Only the bench's scenarios can show the rest, because it needs a count across a whole access or a model of the memory:
- the exact number of clocks each strobe is active;
- that a reported length matches the setting in force at acceptance, clamped;
- that read data written earlier comes back through the device model;
- that a request made while busy leaves no trace.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_ACCESS
  } ctrl_state_t;

endpackage

// File: rtl/nvm_len_clamp.sv
module nvm_len_clamp #(
  parameter int CW      = 8,
  parameter int MIN_CYC = 2
) (
  input  logic [CW-1:0] len_in,
  output logic [CW-1:0] len_out
);

  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

  always_comb begin
    len_out = (len_in < MIN_V) ? MIN_V : len_in;
  end

endmodule

// File: rtl/nvm_access_timer.sv
module nvm_access_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(1);
    end else if (run) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/nvm_cycle_ctrl.sv
module nvm_cycle_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CW      = 8,
  parameter int MIN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] rd_cycles,
  input  logic [CW-1:0] wr_cycles,
  output logic          req_ready,
  output logic          done,
  output logic          done_write,
  output logic [CW-1:0] done_cycles,
  output logic [DW-1:0] done_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam logic [CW-1:0] ONE = CW'(1);

  ctrl_state_t   state;
  logic          is_wr;
  logic [CW-1:0] len_q;
  logic [CW-1:0] rd_len;
  logic [CW-1:0] wr_len;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          last_clk;
  logic          we_release;

  // Both lengths pass through the same clamp.
  nvm_len_clamp #(.CW(CW), .MIN_CYC(MIN_CYC)) u_rd_clamp (
    .len_in (rd_cycles),
    .len_out(rd_len)
  );

  nvm_len_clamp #(.CW(CW), .MIN_CYC(MIN_CYC)) u_wr_clamp (
    .len_in (wr_cycles),
    .len_out(wr_len)
  );

  assign accept     = (state == ST_IDLE) && req_valid;
  assign last_clk   = (state == ST_ACCESS) && (cnt == len_q);
  assign we_release = (state == ST_ACCESS) && is_wr && (cnt == len_q - ONE);
  assign req_ready  = (state == ST_IDLE);

  // Counts the clocks of the access in progress: 1 on its first clock.
  nvm_access_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .run  (state == ST_ACCESS),
    .cnt  (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      is_wr       <= 1'b0;
      len_q       <= '0;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dq_oe   <= 1'b0;
      mem_addr    <= '0;
      mem_dq_out  <= '0;
      done        <= 1'b0;
      done_write  <= 1'b0;
      done_cycles <= '0;
      done_rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state    <= ST_ACCESS;
        is_wr    <= req_write;
        len_q    <= req_write ? wr_len : rd_len;
        mem_addr <= req_addr;
        mem_ce_n <= 1'b0;
        if (req_write) begin
          mem_we_n   <= 1'b0;
          mem_dq_oe  <= 1'b1;
          mem_dq_out <= req_wdata;
        end else begin
          mem_oe_n <= 1'b0;
        end
      end
      if (we_release) begin
        mem_we_n <= 1'b1;
      end
      if (last_clk) begin
        state       <= ST_IDLE;
        mem_ce_n    <= 1'b1;
        mem_oe_n    <= 1'b1;
        mem_we_n    <= 1'b1;
        mem_dq_oe   <= 1'b0;
        done        <= 1'b1;
        done_write  <= is_wr;
        done_cycles <= cnt;
        if (!is_wr) begin
          done_rdata <= mem_dq_in;
        end
      end
    end
  end

endmodule

// File: rtl/nvm_cycle_ctrl_chk.sv
module nvm_cycle_ctrl_chk #(
  parameter int AW      = 18,
  parameter int CW      = 8,
  parameter int MIN_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          done,
  input logic          done_write,
  input logic [CW-1:0] done_cycles,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);

  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_read_oe_last_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !done_write) |-> ($past(!mem_oe_n) && $past(mem_we_n)));

  p_we_high_last_r3: assert property (@(posedge clk) disable iff (rst)
    (done && done_write) |-> ($past(mem_we_n) && $past(mem_dq_oe)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_len_min_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_cycles >= MIN_V));

  p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_dq_write_only_r9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind nvm_cycle_ctrl nvm_cycle_ctrl_chk #(.AW(AW), .CW(CW), .MIN_CYC(MIN_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .done       (done),
  .done_write (done_write),
  .done_cycles(done_cycles),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/nvm_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_cycle_ctrl_bench;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] rd_cycles = 8'd4;
  logic [CW-1:0] wr_cycles = 8'd4;
  logic          req_ready;
  logic          done;
  logic          done_write;
  logic [CW-1:0] done_cycles;
  logic [DW-1:0] done_rdata;
  logic          mem_ce_n;
  logic          mem_oe_n;
  logic          mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvm_cycle_ctrl u_nvm_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_cycles(rd_cycles),
    .wr_cycles(wr_cycles), .req_ready(req_ready), .done(done),
    .done_write(done_write), .done_cycles(done_cycles), .done_rdata(done_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Device model: stores on the rising edge of write enable, and returns data only while output enable is low.
  logic [DW-1:0] mem [16] = '{default: '0};
  always @(posedge mem_we_n) if (!mem_ce_n) mem[mem_addr[3:0]] <= mem_dq_out;
  assign mem_dq_in = mem_oe_n ? 16'h0BAD : mem[mem_addr[3:0]];

  // Stimulus and expected results
  localparam bit            VW  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [AW-1:0] VA  [NV] = '{18'h00001, 18'h00001, 18'h3FFF2, 18'h3FFF2, 18'h00013, 18'h00013};
  localparam logic [DW-1:0] VD  [NV] = '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 16'hA5A5, 16'h0000};
  localparam logic [CW-1:0] VRC [NV] = '{8'd9, 8'd3, 8'd7, 8'd0, 8'd50, 8'd50};
  localparam logic [CW-1:0] VWC [NV] = '{8'd5, 8'd11, 8'd1, 8'd6, 8'd20, 8'd2};
  localparam int            VL  [NV] = '{5, 3, 2, 2, 20, 50};
  localparam logic [DW-1:0] VEX [NV] = '{16'h0000, 16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 16'hA5A5};

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_access(input int id, input bit w, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [CW-1:0] rc,
                            input logic [CW-1:0] wc, input int el,
                            input logic [DW-1:0] er);
    int n_ce = 0, n_oe = 0, n_we = 0, n_dq = 0;
    int n_both = 0, n_badaddr = 0, n_baddq = 0, k = 0;
    @(negedge clk);
    chk($sformatf("R1 v%0d ready before request", id), req_ready, 1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    rd_cycles = rc; wr_cycles = wc;
    @(negedge clk);
    req_valid = 1'b0; req_addr = a ^ 18'h15555; req_wdata = ~d;
    while (!done && k < 400) begin
      k++;
      if (!mem_ce_n) n_ce++;
      if (!mem_oe_n) n_oe++;
      if (!mem_we_n) n_we++;
      if (mem_dq_oe) n_dq++;
      if (!mem_oe_n && !mem_we_n) n_both++;
      if (mem_addr != a) n_badaddr++;
      if (mem_dq_oe && mem_dq_out != d) n_baddq++;
      if (k == 1) begin rd_cycles = 8'd60; wr_cycles = 8'd60; end   // R8
      if (k == 2) begin req_valid = 1'b1; req_addr = 18'h2AAAA; end // R10
      else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk($sformatf("R5 v%0d done pulse seen", id), done, 1);
    chk($sformatf("R2/R3 v%0d chip select clocks", id), n_ce, el);
    chk($sformatf("R2 v%0d output enable clocks", id), n_oe, w ? 0 : el);
    chk($sformatf("R3 v%0d write enable clocks", id), n_we, w ? el - 1 : 0);
    chk($sformatf("R3 v%0d drive enable clocks", id), n_dq, w ? el : 0);
    chk($sformatf("R3 v%0d driven data mismatches", id), n_baddq, 0);
    chk($sformatf("R9 v%0d oe/we overlap clocks", id), n_both, 0);
    chk($sformatf("R11 v%0d address mismatches", id), n_badaddr, 0);
    chk($sformatf("R5/R6/R7/R8 v%0d measured length", id), done_cycles, el);
    chk($sformatf("R5 v%0d done kind", id), done_write, w);
    if (!w) chk($sformatf("R4 v%0d read data", id), done_rdata, er);
    @(negedge clk);
    chk($sformatf("R5 v%0d done one clock", id), done, 0);
    chk($sformatf("R10 v%0d no stray access", id), mem_ce_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ce_n", mem_ce_n, 1);
    chk("R1 reset oe_n/we_n", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R1 reset drive enable", mem_dq_oe, 0);
    chk("R1 reset ready", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    for (int i = 0; i < NV; i++)
      run_access(i, VW[i], VA[i], VD[i], VRC[i], VWC[i], VL[i], VEX[i]);

    // Reset applied in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00004;
    req_wdata = 16'h7777; wr_cycles = 8'd10;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 write in progress before reset", mem_we_n, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-access pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset mid-access", req_ready, 1);

    // A read after the reset, with length 1 raised to 2
    run_access(10, 1'b0, 18'h00001, 16'h0000, 8'd1, 8'd33, 2, 16'h1234);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule